// File: doc/BRIEF.md
# USB Endpoint DMA Request Controller

This block sits between the receive FIFOs of a USB device controller and a bus-master DMA engine. It decides, for each endpoint channel, when to ask the DMA engine to unload a received packet. It holds the request until the engine has taken every byte of that packet. It also raises interrupts so that the processor knows when a packet or a whole transfer has finished, and when a packet is waiting that the DMA engine will not take.

Each channel works on its own and has two modes. Single-packet mode (mode 0) raises a request whenever the FIFO reports a non-empty packet. It completes after that one packet, so software sets the channel up again for each packet; this mode suits any endpoint type. Bulk mode (mode 1) runs through a transfer of many packets without involving the processor. A request starts only when the packet-ready flag rises and the packet carries exactly the maximum packet size. A shorter packet, including a zero-length one, ends the transfer. The channel then reports the number of bytes moved and leaves the short packet in the FIFO. A packet that arrived before the channel was armed produces no request in bulk mode. Software drains it by switching the channel to single-packet mode.

Each DMA beat carries one byte. The packet-clear pulse tells the FIFO to drop its packet-ready flag.

Top module: `usb_dreq_top`

## Requirements
- R1: After reset every request, clear and interrupt output is low and every byte-count output reads zero.
- R2: In mode 0 (mode select = 0), an idle channel with enable and request enable both high, packet-ready high and a non-zero byte count raises its request one clock later. With request enable low it raises no request.
- R3: A request stays high until the channel has received as many beat acknowledgements as the packet's byte count. It falls in the clock after the last acknowledgement, and the packet-clear output pulses high for exactly that one clock.
- R4: In mode 0 the completion interrupt pulses together with the packet-clear pulse, and the byte-count output then equals the packet's byte count.
- R5: In mode 1 (mode select = 1), a request starts only in the clock after packet-ready rises while the byte count equals the maximum packet size. Full-size packets in mode 1 produce a packet-clear pulse but no completion interrupt.
- R6: A rising edge of packet-ready while the channel is disabled or its request enable is low pulses the receive interrupt one clock later. A packet that is already present when the channel is armed in mode 1 raises no request. Switching that channel to mode 0 makes it request the packet.
- R7: In mode 1, a packet-ready rising edge with a byte count below the maximum packet size raises no request. It pulses the completion interrupt one clock later, with the byte-count output equal to the sum of the full-size packets moved since the previous completion.
- R8: Changes to enable or mode select while a request is pending do not alter that packet's handling. The packet completes with the behaviour of the mode in which it started.
- R9: Channels are independent. Acknowledgements, settings and packets on one channel do not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | NUM_CH | Channel enable, one bit per channel |
| ch_req_en | input | NUM_CH | DMA request enable, one bit per channel |
| ch_mode | input | NUM_CH | Mode select: 0 single packet, 1 bulk transfer |
| pkt_rdy | input | NUM_CH | FIFO packet-ready flag per channel |
| rx_cnt | input | NUM_CH x CNT_W | Received byte count per channel |
| max_pkt | input | NUM_CH x CNT_W | Configured maximum packet size per channel |
| beat_ack | input | NUM_CH | DMA engine accepted one byte this clock |
| dma_req | output | NUM_CH | DMA request line per channel |
| pkt_clr | output | NUM_CH | One-clock pulse: packet fully unloaded, clear packet-ready |
| done_irq | output | NUM_CH | One-clock completion interrupt pulse |
| rx_irq | output | NUM_CH | One-clock receive interrupt pulse for a packet not handled by DMA |
| xfer_bytes | output | NUM_CH x TOT_W | Bytes moved, updated with each completion interrupt |

## Verification
On every cycle the assertions check several protocol rules. A request falls only after an acknowledgement, and a pending request without an acknowledgement stays high. The packet-clear pulse coincides with the fall of the request. A request rises only on an armed channel, and a bulk-mode start only ever follows a full-size count. The ordering and timing effects need the directed scenarios: the missed-edge case for a packet present before arming, the recovery through mode 0, the running byte total ended by a short packet, mode changes in the middle of a packet, and the separation between channels.

// File: rtl/usb_dreq_pkg.sv
package usb_dreq_pkg;
    localparam int DEF_NUM_CH = 8;
    localparam int DEF_CNT_W  = 11;
    localparam int DEF_TOT_W  = 20;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_MOVE = 1'b1
    } chan_st_e;
endpackage

// File: rtl/usb_dreq_rise.sv
module usb_dreq_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = d & ~prev_q;
endmodule

// File: rtl/usb_dreq_chan.sv
module usb_dreq_chan
    import usb_dreq_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int TOT_W = DEF_TOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             req_en,
    input  logic             mode,
    input  logic             pkt_rdy,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             beat_ack,
    output logic             dma_req,
    output logic             pkt_clr,
    output logic             done_irq,
    output logic             rx_irq,
    output logic [TOT_W-1:0] xfer_bytes
);
    localparam logic [CNT_W-1:0] ONE_BEAT = CNT_W'(1);

    typedef struct packed {
        chan_st_e        st;
        logic            bulk;
        logic [CNT_W-1:0] left;
        logic [CNT_W-1:0] pkt;
        logic [TOT_W-1:0] acc;
        logic [TOT_W-1:0] bytes;
        logic            clr;
        logic            done;
        logic            rxi;
    } chan_s;

    chan_s s_d, s_q;
    logic  rdy_rise;

    usb_dreq_rise u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pkt_rdy),
        .rise (rdy_rise)
    );

    always_comb begin
        s_d      = s_q;
        s_d.clr  = 1'b0;
        s_d.done = 1'b0;
        s_d.rxi  = 1'b0;
        unique case (s_q.st)
            CH_IDLE: begin
                if (en && req_en) begin
                    if (!mode) begin
                        if (pkt_rdy && (rx_cnt != '0)) begin
                            s_d.st   = CH_MOVE;
                            s_d.bulk = 1'b0;
                            s_d.left = rx_cnt;
                            s_d.pkt  = rx_cnt;
                        end
                    end else if (rdy_rise) begin
                        if (rx_cnt == max_pkt) begin
                            s_d.st   = CH_MOVE;
                            s_d.bulk = 1'b1;
                            s_d.left = rx_cnt;
                            s_d.pkt  = rx_cnt;
                        end else begin
                            s_d.done  = 1'b1;
                            s_d.bytes = s_q.acc;
                            s_d.acc   = '0;
                        end
                    end
                end else if (rdy_rise) begin
                    s_d.rxi = 1'b1;
                end
            end
            CH_MOVE: begin
                if (beat_ack) begin
                    s_d.left = s_q.left - ONE_BEAT;
                    if (s_q.left == ONE_BEAT) begin
                        s_d.st  = CH_IDLE;
                        s_d.clr = 1'b1;
                        if (s_q.bulk) begin
                            s_d.acc = s_q.acc + TOT_W'(s_q.pkt);
                        end else begin
                            s_d.done  = 1'b1;
                            s_d.bytes = TOT_W'(s_q.pkt);
                            s_d.acc   = '0;
                        end
                    end
                end
            end
            default: s_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dma_req    = (s_q.st == CH_MOVE);
    assign pkt_clr    = s_q.clr;
    assign done_irq   = s_q.done;
    assign rx_irq     = s_q.rxi;
    assign xfer_bytes = s_q.bytes;
endmodule

// File: rtl/usb_dreq_top.sv
module usb_dreq_top
    import usb_dreq_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int TOT_W  = DEF_TOT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             ch_en,
    input  logic [NUM_CH-1:0]             ch_req_en,
    input  logic [NUM_CH-1:0]             ch_mode,
    input  logic [NUM_CH-1:0]             pkt_rdy,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rx_cnt,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  max_pkt,
    input  logic [NUM_CH-1:0]             beat_ack,
    output logic [NUM_CH-1:0]             dma_req,
    output logic [NUM_CH-1:0]             pkt_clr,
    output logic [NUM_CH-1:0]             done_irq,
    output logic [NUM_CH-1:0]             rx_irq,
    output logic [NUM_CH-1:0][TOT_W-1:0]  xfer_bytes
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        usb_dreq_chan #(
            .CNT_W(CNT_W),
            .TOT_W(TOT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[c]),
            .req_en    (ch_req_en[c]),
            .mode      (ch_mode[c]),
            .pkt_rdy   (pkt_rdy[c]),
            .rx_cnt    (rx_cnt[c]),
            .max_pkt   (max_pkt[c]),
            .beat_ack  (beat_ack[c]),
            .dma_req   (dma_req[c]),
            .pkt_clr   (pkt_clr[c]),
            .done_irq  (done_irq[c]),
            .rx_irq    (rx_irq[c]),
            .xfer_bytes(xfer_bytes[c])
        );
    end
endmodule

// File: rtl/usb_dreq_chk.sv
module usb_dreq_chk #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 11
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            ch_en,
    input logic [NUM_CH-1:0]            ch_req_en,
    input logic [NUM_CH-1:0]            ch_mode,
    input logic [NUM_CH-1:0][CNT_W-1:0] rx_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] max_pkt,
    input logic [NUM_CH-1:0]            beat_ack,
    input logic [NUM_CH-1:0]            dma_req,
    input logic [NUM_CH-1:0]            pkt_clr,
    input logic [NUM_CH-1:0]            done_irq,
    input logic [NUM_CH-1:0]            rx_irq
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R3: a request only falls after an acknowledgement
        a_r3_fall_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dma_req[c]) |-> $past(beat_ack[c]))
            else $error("a_r3_fall_after_ack ch %0d", c);

        // R3: an unacknowledged request persists
        a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_req[c] && !beat_ack[c]) |=> dma_req[c])
            else $error("a_r3_req_holds ch %0d", c);

        // R3: packet clear coincides with the request falling
        a_r3_clr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
            pkt_clr[c] |-> (!dma_req[c] && $past(dma_req[c])))
            else $error("a_r3_clr_on_fall ch %0d", c);

        // R2: a request only rises on an armed channel
        a_r2_rise_armed: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dma_req[c]) |-> $past(ch_en[c] && ch_req_en[c]))
            else $error("a_r2_rise_armed ch %0d", c);

        // R5: a bulk-mode start only follows a full-size count
        a_r5_bulk_full: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(dma_req[c]) && $past(ch_mode[c])) |-> $past(rx_cnt[c] == max_pkt[c]))
            else $error("a_r5_bulk_full ch %0d", c);

        // R6: receive interrupt and completion interrupt are never raised together
        a_r6_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(rx_irq[c] && done_irq[c]))
            else $error("a_r6_irq_excl ch %0d", c);
    end
endmodule

bind usb_dreq_top usb_dreq_chk #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_en    (ch_en),
    .ch_req_en(ch_req_en),
    .ch_mode  (ch_mode),
    .rx_cnt   (rx_cnt),
    .max_pkt  (max_pkt),
    .beat_ack (beat_ack),
    .dma_req  (dma_req),
    .pkt_clr  (pkt_clr),
    .done_irq (done_irq),
    .rx_irq   (rx_irq)
);

// File: tb/sim_usb_dreq_top.sv
`timescale 1ns/1ps
module sim_usb_dreq_top;
    localparam int N  = 8;
    localparam int CW = 11;
    localparam int TW = 20;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N-1:0]        ch_en = '0, ch_req_en = '0, ch_mode = '0, pkt_rdy = '0, beat_ack = '0;
    logic [N-1:0][CW-1:0] rx_cnt = '0, max_pkt = '0;
    logic [N-1:0]        dma_req, pkt_clr, done_irq, rx_irq;
    logic [N-1:0][TW-1:0] xfer_bytes;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    usb_dreq_top #(.NUM_CH(N), .CNT_W(CW), .TOT_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_req_en(ch_req_en),
        .ch_mode(ch_mode), .pkt_rdy(pkt_rdy), .rx_cnt(rx_cnt), .max_pkt(max_pkt),
        .beat_ack(beat_ack), .dma_req(dma_req), .pkt_clr(pkt_clr),
        .done_irq(done_irq), .rx_irq(rx_irq), .xfer_bytes(xfer_bytes)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Acknowledge n beats on channel ch; return what is seen after the last one.
    task automatic pump(input int ch, input int n, output bit held, output bit clr,
                        output bit done, output int bytes, output bit req_after);
        held = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (!dma_req[ch]) held = 1'b0;
            beat_ack[ch] = 1'b1;
            @(negedge clk);
        end
        beat_ack[ch] = 1'b0;
        clr       = pkt_clr[ch];
        done      = done_irq[ch];
        bytes     = int'(xfer_bytes[ch]);
        req_after = dma_req[ch];
        pkt_rdy[ch] = 1'b0;
    endtask

    task automatic t_reset();
        check(dma_req == '0 && pkt_clr == '0 && done_irq == '0 && rx_irq == '0,
              "R1 outputs low", int'(dma_req | pkt_clr | done_irq | rx_irq), 0);
        check(xfer_bytes == '0, "R1 byte counts zero", int'(xfer_bytes[0]), 0);
    endtask

    task automatic t_mode0(input int ch, input int cnt);
        bit held, clr, done, ra; int bytes;
        ch_en[ch] = 1; ch_req_en[ch] = 1; ch_mode[ch] = 0;
        rx_cnt[ch] = CW'(cnt); pkt_rdy[ch] = 1;
        @(negedge clk);
        check(dma_req[ch], "R2 mode 0 request raised", int'(dma_req[ch]), 1);
        pump(ch, cnt, held, clr, done, bytes, ra);
        check(held, "R3 request held until last beat", int'(held), 1);
        check(!ra && clr, "R3 request falls with clear pulse", int'({ra, clr}), 1);
        check(done && bytes == cnt, "R4 completion with byte count", bytes, cnt);
        @(negedge clk);
        check(!pkt_clr[ch] && !done_irq[ch], "R3 clear is one clock", int'(pkt_clr[ch]), 0);
    endtask

    task automatic t_gate(input int ch);
        bit held, clr, done, ra; int bytes;
        ch_en[ch] = 1; ch_req_en[ch] = 0; ch_mode[ch] = 0;
        rx_cnt[ch] = CW'(3); pkt_rdy[ch] = 1;
        @(negedge clk);
        check(rx_irq[ch], "R6 receive interrupt when request disabled", int'(rx_irq[ch]), 1);
        repeat (3) @(negedge clk);
        check(!dma_req[ch], "R2 no request without request enable", int'(dma_req[ch]), 0);
        ch_req_en[ch] = 1;
        @(negedge clk);
        check(dma_req[ch], "R2 request once enabled", int'(dma_req[ch]), 1);
        pump(ch, 3, held, clr, done, bytes, ra);
        check(done && bytes == 3, "R4 gated packet completes", bytes, 3);
    endtask

    task automatic t_bulk(input int ch);
        bit held, clr, done, ra; int bytes;
        ch_en[ch] = 1; ch_req_en[ch] = 1; ch_mode[ch] = 1; max_pkt[ch] = CW'(8);
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            rx_cnt[ch] = CW'(8); pkt_rdy[ch] = 1;
            @(negedge clk);
            check(dma_req[ch], "R5 bulk request on full-size edge", int'(dma_req[ch]), 1);
            pump(ch, 8, held, clr, done, bytes, ra);
            check(held && clr && !ra, "R3 bulk packet cleared", int'(clr), 1);
            check(!done, "R5 no completion per bulk packet", int'(done), 0);
        end
        @(negedge clk);
        rx_cnt[ch] = CW'(3); pkt_rdy[ch] = 1;
        @(negedge clk);
        check(done_irq[ch], "R7 short packet completes transfer", int'(done_irq[ch]), 1);
        check(int'(xfer_bytes[ch]) == 16, "R7 transfer total", int'(xfer_bytes[ch]), 16);
        repeat (3) @(negedge clk);
        check(!dma_req[ch], "R7 short packet not requested", int'(dma_req[ch]), 0);
        pkt_rdy[ch] = 0;
    endtask

    task automatic t_preload(input int ch);
        bit held, clr, done, ra; int bytes;
        max_pkt[ch] = CW'(8); rx_cnt[ch] = CW'(8); pkt_rdy[ch] = 1;
        @(negedge clk);
        check(rx_irq[ch], "R6 receive interrupt while disabled", int'(rx_irq[ch]), 1);
        ch_en[ch] = 1; ch_req_en[ch] = 1; ch_mode[ch] = 1;
        repeat (5) @(negedge clk);
        check(!dma_req[ch], "R6 preloaded packet ignored in mode 1", int'(dma_req[ch]), 0);
        ch_mode[ch] = 0;
        @(negedge clk);
        check(dma_req[ch], "R6 mode 0 recovers preloaded packet", int'(dma_req[ch]), 1);
        pump(ch, 8, held, clr, done, bytes, ra);
        check(clr && done && bytes == 8, "R6 recovery completes", bytes, 8);
    endtask

    task automatic t_boundary(input int ch);
        bit held, clr, done, ra; int bytes;
        ch_en[ch] = 1; ch_req_en[ch] = 1; ch_mode[ch] = 0;
        rx_cnt[ch] = CW'(4); pkt_rdy[ch] = 1;
        @(negedge clk);
        ch_en[ch] = 0; ch_mode[ch] = 1;
        @(negedge clk);
        check(dma_req[ch], "R8 request kept after disable", int'(dma_req[ch]), 1);
        pump(ch, 4, held, clr, done, bytes, ra);
        check(held && clr, "R8 packet finished", int'(clr), 1);
        check(done && bytes == 4, "R8 packet handled in starting mode", int'(done), 1);
    endtask

    task automatic t_indep();
        bit held, clr, done, ra; int bytes;
        ch_en[6] = 1; ch_req_en[6] = 1; ch_mode[6] = 0; rx_cnt[6] = CW'(6);
        ch_en[7] = 1; ch_req_en[7] = 1; ch_mode[7] = 1; rx_cnt[7] = CW'(6); max_pkt[7] = CW'(6);
        pkt_rdy[6] = 1; pkt_rdy[7] = 1;
        @(negedge clk);
        check(dma_req[6] && dma_req[7], "R9 both channels request", int'(dma_req[7:6]), 3);
        pump(6, 6, held, clr, done, bytes, ra);
        check(clr && done && !ra, "R9 channel 6 done", int'(done), 1);
        check(dma_req[7] && !pkt_clr[7], "R9 channel 7 untouched", int'(dma_req[7]), 1);
        pump(7, 6, held, clr, done, bytes, ra);
        check(held && clr && !done, "R9 channel 7 bulk packet", int'({clr, done}), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0(0, 5);
        t_mode0(3, 64);
        t_gate(1);
        t_bulk(2);
        t_preload(4);
        t_boundary(5);
        t_indep();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule